// File: doc/BRIEF.md
# Control Endpoint Descriptor Streamer

This block takes descriptor returns on the control endpoint off a small processor. Each SETUP stage the endpoint logic decodes arrives as one 8-byte word. The block keeps that word in a dedicated buffer, and the processor reads it one byte at a time through an index. To answer a descriptor request, the processor writes the 16-bit start address of the descriptor into a pointer register. After that write the processor has nothing more to do.

After the pointer write, the block reads the descriptor header over a byte-wide synchronous memory port. From that header it works out how many bytes to return, then clips that count to the length the host asked for. It then serves the data stage on a token/handshake interface whose tokens are already decoded. Each IN token gets one packet of at most 64 bytes, read straight from memory. A packet the host did not acknowledge is sent again unchanged. When the host acknowledges the final packet, the block sets a done flag and pulses an interrupt. A new SETUP stage cancels any transfer in progress.

Top module: `ep0_desc_streamer`

## Requirements
- R1: A one-cycle `setup_vld` stores the 8 bytes of `setup_pkt` (byte i at bits 8i+7..8i), replacing any earlier stage; `setup_rd_data` returns the stored byte selected by `setup_rd_idx`.
- R2: An IN token that arrives while no packet is armed (idle, header fetch in progress, transfer finished or aborted) is answered by a one-cycle `tx_nak` in the cycle after the token is sampled.
- R3: The byte count is taken from the header at the pointer address. If header byte 1 equals 0x02, the count is the 16-bit little-endian value in header bytes 2 (low) and 3 (high). Otherwise the count is header byte 0. The result is clipped to the requested length held in SETUP bytes 6 (low) and 7 (high).
- R4: The data bytes are the memory bytes starting at the pointer address, in ascending address order. They are split into packets of 64 bytes, with only the last packet shorter. Each byte appears with `tx_valid`, and `tx_last` marks the final byte of a packet.
- R5: The first byte of a packet appears two cycles after its IN token is sampled, and the remaining bytes follow on consecutive cycles.
- R6: When the byte count is a multiple of 64 (zero included), the transfer ends with a zero-length packet. This is signalled by a one-cycle `tx_zlp`, one cycle after the IN token.
- R7: After `hs_timeout`, the next IN token resends the same bytes with the same data toggle.
- R8: `tx_data1` is 1 for the first packet of each transfer and inverts only when a packet is acknowledged with `hs_ack`.
- R9: Acknowledging a packet shorter than 64 bytes sets `xfer_done` and pulses `done_irq` for one cycle, one cycle after `hs_ack`. A new pointer write or a SETUP stage clears `xfer_done`.
- R10: A SETUP stage during a transfer aborts it. No further data goes out, later IN tokens are NAKed, and `xfer_done` stays clear. If a SETUP stage and a pointer write arrive in the same cycle, the SETUP stage wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_vld | input | 1 | SETUP stage received (one cycle) |
| setup_pkt | input | 64 | The 8 SETUP bytes, byte 0 in the low bits |
| setup_rd_idx | input | 3 | Processor read index into the SETUP buffer |
| setup_rd_data | output | 8 | Selected SETUP byte |
| ptr_wr | input | 1 | Processor write of the descriptor pointer |
| ptr_wdata | input | 16 | Descriptor start address |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| in_tok | input | 1 | IN token for the control endpoint (one cycle) |
| hs_ack | input | 1 | Host acknowledged the last packet |
| hs_timeout | input | 1 | Host did not acknowledge the last packet |
| tx_valid | output | 1 | Packet data byte valid |
| tx_data | output | 8 | Packet data byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_zlp | output | 1 | Send a zero-length packet (one cycle) |
| tx_nak | output | 1 | Answer the token with NAK (one cycle) |
| tx_data1 | output | 1 | Data toggle: 1 selects DATA1, 0 selects DATA0 |
| xfer_done | output | 1 | Transfer finished |
| done_irq | output | 1 | One-cycle interrupt when the transfer finishes |

## Verification
Each result has a fixed latency, counted from the clock edge that samples the stimulus. NAK and zero-length replies appear one cycle after the token. The first data byte appears two cycles after the token, and the following bytes come one per cycle. The interrupt appears one cycle after the acknowledge. The header byte count is ready within seven cycles of the pointer write. The bench drives every input on a falling edge and reads each result at the falling edge where it is due. It waits ten cycles after a pointer write, so the header fetch is always complete before the first token. A separate directed case sends a token right after the pointer write to catch the NAK given during the fetch.

// File: rtl/ep0_desc_pkg.sv
package ep0_desc_pkg;
  localparam int SETUP_NB     = 8;
  localparam int WLEN_LO_BYTE = 6;
  localparam int HDR_NB       = 4;
  localparam logic [7:0] CFG_TYPE = 8'h02;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2,
    ST_HS   = 2'd3
  } strm_state_t;
endpackage

// File: rtl/ep0_setup_buf.sv
module ep0_setup_buf
  import ep0_desc_pkg::*;
#(
  parameter int NB = SETUP_NB,
  localparam int IW = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NB*8-1:0] wr_pkt,
  input  logic [IW-1:0]   rd_idx,
  output logic [7:0]      rd_data,
  output logic [15:0]     wlen
);
  logic [7:0] byte_q [NB];

  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     byte_q[g] <= '0;
      else if (wr_en) byte_q[g] <= wr_pkt[8*g +: 8];
    end
  end

  assign rd_data = byte_q[rd_idx];
  assign wlen    = {byte_q[WLEN_LO_BYTE+1], byte_q[WLEN_LO_BYTE]};
endmodule

// File: rtl/ep0_len_fetch.sv
module ep0_len_fetch
  import ep0_desc_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [AW-1:0] base,
  input  logic [7:0]    mem_rdata,
  input  logic [15:0]   wlen,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          done,
  output logic [LW-1:0] xfer_len
);
  localparam logic [2:0] N_ISSUE = 3'(HDR_NB);
  localparam logic [2:0] N_DONE  = 3'(HDR_NB + 1);

  logic       busy_q, busy_n;
  logic [2:0] cnt_q, cnt_n;
  logic       vq_q, vq_n;
  logic [1:0] idx_q, idx_n;
  logic [7:0] hdr_q [HDR_NB];
  logic [LW-1:0] desc_len, req_len;

  assign rd_en   = busy_q && (cnt_q < N_ISSUE);
  assign rd_addr = base + AW'(cnt_q);
  assign done    = busy_q && (cnt_q == N_DONE);

  assign desc_len = (hdr_q[1] == CFG_TYPE) ? LW'({hdr_q[3], hdr_q[2]})
                                           : LW'(hdr_q[0]);
  assign req_len  = LW'(wlen);
  assign xfer_len = (desc_len < req_len) ? desc_len : req_len;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    vq_n   = rd_en && !abort && !start;
    idx_n  = cnt_q[1:0];
    if (abort) begin
      busy_n = 1'b0;
    end else if (start) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (busy_q) begin
      if (done) busy_n = 1'b0;
      else      cnt_n  = cnt_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      vq_q   <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      vq_q   <= vq_n;
      idx_q  <= idx_n;
    end
  end

  for (genvar g = 0; g < HDR_NB; g++) begin : g_hdr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           hdr_q[g] <= '0;
      else if (vq_q && (idx_q == 2'(g)))    hdr_q[g] <= mem_rdata;
    end
  end
endmodule

// File: rtl/ep0_pkt_engine.sv
module ep0_pkt_engine
  import ep0_desc_pkg::*;
#(
  parameter int AW  = 16,
  parameter int LW  = 16,
  parameter int MPS = 64,
  localparam int CW = $clog2(MPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kill,
  input  logic          load,
  input  logic [LW-1:0] xfer_len,
  input  logic [AW-1:0] base,
  input  logic          in_tok,
  input  logic          hs_ack,
  input  logic          hs_timeout,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          tx_valid,
  output logic          tx_last,
  output logic          tx_zlp,
  output logic          tx_nak,
  output logic          tx_data1,
  output logic          xfer_done,
  output logic          done_irq
);
  localparam logic [LW-1:0] MPS_L = LW'(MPS);
  localparam logic [CW-1:0] MPS_C = CW'(MPS);

  strm_state_t   st_q, st_n;
  logic [LW-1:0] rem_q, rem_n, sent_q, sent_n;
  logic [CW-1:0] pkt_q, pkt_n, idx_q, idx_n, plen_w;
  logic          tog_q, tog_n, done_q, done_n;
  logic          rdv_q, rdv_n, last_q, last_n;
  logic          zlp_q, zlp_n, nak_q, nak_n, irq_q, irq_n;
  logic          last_iss;

  assign plen_w   = (rem_q >= MPS_L) ? MPS_C : rem_q[CW-1:0];
  assign last_iss = (idx_q == pkt_q - CW'(1));
  assign rd_en    = (st_q == ST_SEND) && !kill;
  assign rd_addr  = base + sent_q[AW-1:0] + AW'(idx_q);

  always_comb begin
    st_n   = st_q;
    rem_n  = rem_q;
    sent_n = sent_q;
    pkt_n  = pkt_q;
    idx_n  = idx_q;
    tog_n  = tog_q;
    done_n = done_q;
    rdv_n  = 1'b0;
    last_n = 1'b0;
    zlp_n  = 1'b0;
    nak_n  = 1'b0;
    irq_n  = 1'b0;
    if (kill) begin
      st_n   = ST_IDLE;
      done_n = 1'b0;
    end else begin
      if (in_tok && (st_q != ST_WAIT)) nak_n = 1'b1;
      if (load) begin
        st_n   = ST_WAIT;
        rem_n  = xfer_len;
        sent_n = '0;
        tog_n  = 1'b1;
        done_n = 1'b0;
      end else begin
        unique case (st_q)
          ST_WAIT: begin
            if (in_tok) begin
              pkt_n = plen_w;
              idx_n = '0;
              if (plen_w == '0) begin
                zlp_n = 1'b1;
                st_n  = ST_HS;
              end else begin
                st_n  = ST_SEND;
              end
            end
          end
          ST_SEND: begin
            rdv_n  = 1'b1;
            last_n = last_iss;
            idx_n  = idx_q + CW'(1);
            if (last_iss) st_n = ST_HS;
          end
          ST_HS: begin
            if (hs_ack) begin
              tog_n = ~tog_q;
              if (pkt_q == MPS_C) begin
                sent_n = sent_q + MPS_L;
                rem_n  = rem_q - MPS_L;
                st_n   = ST_WAIT;
              end else begin
                st_n   = ST_IDLE;
                done_n = 1'b1;
                irq_n  = 1'b1;
              end
            end else if (hs_timeout) begin
              st_n = ST_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      sent_q <= '0;
      pkt_q  <= '0;
      idx_q  <= '0;
      tog_q  <= 1'b1;
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      last_q <= 1'b0;
      zlp_q  <= 1'b0;
      nak_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      rem_q  <= rem_n;
      sent_q <= sent_n;
      pkt_q  <= pkt_n;
      idx_q  <= idx_n;
      tog_q  <= tog_n;
      done_q <= done_n;
      rdv_q  <= rdv_n;
      last_q <= last_n;
      zlp_q  <= zlp_n;
      nak_q  <= nak_n;
      irq_q  <= irq_n;
    end
  end

  assign tx_valid  = rdv_q;
  assign tx_last   = last_q;
  assign tx_zlp    = zlp_q;
  assign tx_nak    = nak_q;
  assign tx_data1  = tog_q;
  assign xfer_done = done_q;
  assign done_irq  = irq_q;
endmodule

// File: rtl/ep0_desc_streamer.sv
module ep0_desc_streamer
  import ep0_desc_pkg::*;
#(
  parameter int AW  = 16,
  parameter int LW  = 16,
  parameter int MPS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          setup_vld,
  input  logic [63:0]   setup_pkt,
  input  logic [2:0]    setup_rd_idx,
  output logic [7:0]    setup_rd_data,
  input  logic          ptr_wr,
  input  logic [AW-1:0] ptr_wdata,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  input  logic          in_tok,
  input  logic          hs_ack,
  input  logic          hs_timeout,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_zlp,
  output logic          tx_nak,
  output logic          tx_data1,
  output logic          xfer_done,
  output logic          done_irq
);
  logic [1:0]    rst_pipe_q;
  logic          rst_sync_n;
  logic [AW-1:0] ptr_q;
  logic [15:0]   wlen;
  logic          f_rd, e_rd, f_done, start, kill;
  logic [AW-1:0] f_addr, e_addr;
  logic [LW-1:0] f_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ptr_q <= '0;
    else if (ptr_wr)  ptr_q <= ptr_wdata;
  end

  assign start = ptr_wr && !setup_vld;
  assign kill  = setup_vld || ptr_wr;

  ep0_setup_buf #(.NB(SETUP_NB)) u_sbuf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (setup_vld),
    .wr_pkt  (setup_pkt),
    .rd_idx  (setup_rd_idx),
    .rd_data (setup_rd_data),
    .wlen    (wlen)
  );

  ep0_len_fetch #(.AW(AW), .LW(LW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .abort     (setup_vld),
    .base      (ptr_q),
    .mem_rdata (mem_rdata),
    .wlen      (wlen),
    .rd_en     (f_rd),
    .rd_addr   (f_addr),
    .done      (f_done),
    .xfer_len  (f_len)
  );

  ep0_pkt_engine #(.AW(AW), .LW(LW), .MPS(MPS)) u_eng (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .kill       (kill),
    .load       (f_done),
    .xfer_len   (f_len),
    .base       (ptr_q),
    .in_tok     (in_tok),
    .hs_ack     (hs_ack),
    .hs_timeout (hs_timeout),
    .rd_en      (e_rd),
    .rd_addr    (e_addr),
    .tx_valid   (tx_valid),
    .tx_last    (tx_last),
    .tx_zlp     (tx_zlp),
    .tx_nak     (tx_nak),
    .tx_data1   (tx_data1),
    .xfer_done  (xfer_done),
    .done_irq   (done_irq)
  );

  assign mem_rd_en = f_rd || e_rd;
  assign mem_addr  = f_rd ? f_addr : e_addr;
  assign tx_data   = tx_valid ? mem_rdata : 8'h00;
endmodule

// File: rtl/ep0_desc_streamer_chk.sv
module ep0_desc_streamer_chk (
  input logic clk,
  input logic rst_n,
  input logic setup_vld,
  input logic in_tok,
  input logic hs_ack,
  input logic hs_timeout,
  input logic tx_valid,
  input logic tx_last,
  input logic tx_zlp,
  input logic tx_nak,
  input logic tx_data1,
  input logic xfer_done,
  input logic done_irq
);
  // R2
  nak_follows_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_nak |-> $past(in_tok));

  // R4
  last_inside_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  // R5
  first_byte_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(in_tok, 2));

  // R6
  zlp_follows_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_zlp |-> ($past(in_tok) && !tx_valid));

  // R7
  toggle_kept_on_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_timeout |=> $stable(tx_data1));

  // R8
  toggle_flip_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_data1) |-> $past(hs_ack));

  // R9
  irq_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> ($past(hs_ack) && xfer_done));

  // R10
  setup_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_vld |=> (!tx_valid && !xfer_done && !done_irq));

  // R2
  single_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid, tx_zlp, tx_nak}));
endmodule

bind ep0_desc_streamer ep0_desc_streamer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .setup_vld  (setup_vld),
  .in_tok     (in_tok),
  .hs_ack     (hs_ack),
  .hs_timeout (hs_timeout),
  .tx_valid   (tx_valid),
  .tx_last    (tx_last),
  .tx_zlp     (tx_zlp),
  .tx_nak     (tx_nak),
  .tx_data1   (tx_data1),
  .xfer_done  (xfer_done),
  .done_irq   (done_irq)
);

// File: tb/ep0_desc_streamer_tb.sv
`timescale 1ns/1ps
module ep0_desc_streamer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        setup_vld;
  logic [63:0] setup_pkt;
  logic [2:0]  setup_rd_idx;
  logic [7:0]  setup_rd_data;
  logic        ptr_wr;
  logic [15:0] ptr_wdata;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        in_tok, hs_ack, hs_timeout;
  logic        tx_valid, tx_last, tx_zlp, tx_nak, tx_data1, xfer_done, done_irq;
  logic [7:0]  tx_data;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;
  logic [7:0] mem [1024];

  always #2 clk = ~clk;

  ep0_desc_streamer u_dut (
    .clk(clk), .rst_n(rst_n), .setup_vld(setup_vld), .setup_pkt(setup_pkt),
    .setup_rd_idx(setup_rd_idx), .setup_rd_data(setup_rd_data),
    .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .in_tok(in_tok),
    .hs_ack(hs_ack), .hs_timeout(hs_timeout), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_zlp(tx_zlp), .tx_nak(tx_nak),
    .tx_data1(tx_data1), .xfer_done(xfer_done), .done_irq(done_irq)
  );

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[9:0]];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int b0, input int b1, input int b2,
                                 input int b3, input int wlen);
    int dl;
    dl = (b1 == 2) ? (b3 * 256 + b2) : b0;
    return (dl < wlen) ? dl : wlen;
  endfunction

  task automatic do_setup(input logic [63:0] pkt);
    @(negedge clk); setup_vld = 1'b1; setup_pkt = pkt;
    @(negedge clk); setup_vld = 1'b0;
  endtask

  task automatic do_ptr(input int base);
    @(negedge clk); ptr_wr = 1'b1; ptr_wdata = 16'(base);
    @(negedge clk); ptr_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends one IN token and collects the reply; errs counts byte mismatches vs memory.
  task automatic do_in(input int addr0, output int n, output bit z, output bit k,
                       output bit tg, output int errs, output bit t_ok);
    @(negedge clk); in_tok = 1'b1;
    @(negedge clk); in_tok = 1'b0;
    k = tx_nak; z = tx_zlp; tg = tx_data1;
    n = 0; errs = 0; t_ok = 1'b1;
    if (!k && !z) begin
      @(negedge clk);
      t_ok = tx_valid;
      for (int c = 0; c < 80 && tx_valid; c++) begin
        if (tx_data !== mem[(addr0 + n) & 1023]) errs++;
        n++;
        if (tx_last) break;
        @(negedge clk);
      end
    end
  endtask

  task automatic pulse_hs(input bit ack, output bit irq);
    @(negedge clk); hs_ack = ack; hs_timeout = !ack;
    @(negedge clk); hs_ack = 1'b0; hs_timeout = 1'b0;
    irq = done_irq;
  endtask

  task automatic run_xfer(input int base, input int b0, input int b1, input int b2,
                          input int b3, input int wlen, input int tmo_pct);
    int L, sent, plen, n, errs, n2, errs2;
    bit z, k, tg, t_ok, z2, k2, tg2, t2, irq, etog;
    mem[base] = 8'(b0); mem[base+1] = 8'(b1); mem[base+2] = 8'(b2); mem[base+3] = 8'(b3);
    do_setup({16'(wlen), 16'($urandom), 32'($urandom)});
    do_ptr(base);
    chk(xfer_done == 1'b0, "R9 done cleared by pointer write", int'(xfer_done), 0);
    idle(10);
    L = exp_len(b0, b1, b2, b3, wlen);
    sent = 0; etog = 1'b1;
    for (int p = 0; p < 20; p++) begin
      plen = (L - sent >= 64) ? 64 : L - sent;
      do_in(base + sent, n, z, k, tg, errs, t_ok);
      chk(!k && n == plen, "R3/R4 packet length", n, plen);
      chk(errs == 0, "R4 packet bytes", errs, 0);
      chk(t_ok, "R5 first byte latency", int'(t_ok), 1);
      chk(z == (plen == 0), "R6 zero-length packet", int'(z), int'(plen == 0));
      chk(tg == etog, "R8 data toggle", int'(tg), int'(etog));
      if (int'($urandom_range(99)) < tmo_pct) begin
        pulse_hs(1'b0, irq);
        do_in(base + sent, n2, z2, k2, tg2, errs2, t2);
        chk(n2 == n && z2 == z && errs2 == 0 && tg2 == tg, "R7 resend after timeout",
            n2, n);
      end
      pulse_hs(1'b1, irq);
      etog = !etog;
      chk(irq == (plen < 64), "R9 done interrupt", int'(irq), int'(plen < 64));
      if (plen < 64) break;
      sent += 64;
    end
    chk(xfer_done == 1'b1, "R9 done flag", int'(xfer_done), 1);
    do_in(base, n, z, k, tg, errs, t_ok);
    chk(k == 1'b1 && n == 0, "R2 NAK after completion", int'(k), 1);
  endtask

  initial begin
    int n, errs, ok_cnt;
    bit z, k, tg, t_ok, irq;
    logic [63:0] pk;
    rst_n = 1'b0; setup_vld = 1'b0; setup_pkt = '0; setup_rd_idx = '0;
    ptr_wr = 1'b0; ptr_wdata = '0; in_tok = 1'b0; hs_ack = 1'b0; hs_timeout = 1'b0;
    void'($urandom(32'd4711));
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
    idle(5);
    rst_n = 1'b1;
    idle(4);

    // reset state
    chk(!tx_valid && !tx_zlp && !tx_nak && !xfer_done && !done_irq,
        "R9 reset outputs", int'(xfer_done), 0);

    // R2: token while idle
    do_in(0, n, z, k, tg, errs, t_ok);
    chk(k == 1'b1, "R2 NAK when idle", int'(k), 1);

    // R1: SETUP capture and readback, then overwrite
    for (int rep = 0; rep < 2; rep++) begin
      pk = {32'($urandom), 32'($urandom)};
      do_setup(pk);
      ok_cnt = 0;
      for (int i = 0; i < 8; i++) begin
        setup_rd_idx = 3'(i);
        #1;
        if (setup_rd_data === pk[8*i +: 8]) ok_cnt++;
      end
      chk(ok_cnt == 8, "R1 SETUP readback", ok_cnt, 8);
    end

    // R2: token during header fetch
    do_setup({16'd64, 48'h0});
    mem[100] = 8'd18; mem[101] = 8'd1;
    do_ptr(100);
    do_in(100, n, z, k, tg, errs, t_ok);
    chk(k == 1'b1, "R2 NAK during header fetch", int'(k), 1);
    idle(10);

    // directed transfers
    run_xfer(100, 18, 1, 0, 0, 64, 0);        // R4 short device descriptor
    run_xfer(200, 18, 1, 0, 0, 8, 0);         // R3 clip to requested length
    run_xfer(300, 9, 2, 128, 0, 255, 0);      // R6 multiple of 64 -> ZLP
    run_xfer(400, 9, 2, 44, 1, 200, 50);      // R3 total length 300 clipped to 200, R7
    run_xfer(500, 18, 1, 0, 0, 0, 0);         // R6 zero length

    // R10: abort mid transfer
    mem[600] = 8'd9; mem[601] = 8'd2; mem[602] = 8'd150; mem[603] = 8'd0;
    do_setup({16'd255, 48'h0});
    do_ptr(600);
    idle(10);
    do_in(600, n, z, k, tg, errs, t_ok);
    chk(n == 64 && errs == 0, "R10 first packet before abort", n, 64);
    pulse_hs(1'b1, irq);
    pk = {32'($urandom), 32'($urandom)};
    do_setup(pk);
    setup_rd_idx = 3'd5;
    #1;
    chk(setup_rd_data === pk[47:40], "R10 SETUP buffer overwritten", int'(setup_rd_data),
        int'(pk[47:40]));
    do_in(664, n, z, k, tg, errs, t_ok);
    chk(k == 1'b1 && n == 0, "R10 NAK after abort", int'(k), 1);
    chk(xfer_done == 1'b0, "R10 done stays clear", int'(xfer_done), 0);

    // random transfers
    for (int it = 0; it < 8; it++) begin
      int base, typ;
      base = int'($urandom_range(600));
      typ  = ($urandom_range(1) == 0) ? 2 : int'($urandom_range(1, 7)) + 2;
      run_xfer(base, int'($urandom_range(255)), typ, int'($urandom_range(255)),
               int'($urandom_range(1)), int'($urandom_range(320)), 30);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule